// File: doc/BRIEF.md
# Synchronous Dual-Port Byte-Lane RAM

This block is a true dual-port synchronous memory. Two ports, A and B, each have their own clock, reset, address, write data, read data and control inputs. Either port can read or write any word at any time, and both ports may touch the same word in the same cycle. Each word is split into a low and a high byte lane. A lane is 8 bits wide when the word is 16 bits and 9 bits wide when the word is 18 bits. Writes and output drive are gated per lane.

A port takes part in a cycle only when its active-low enable is low and its active-high enable is high on the same rising clock edge. Every port also has a latency select. In flow-through mode the read result shows up one cycle after the address edge. In pipelined mode it shows up one cycle later again. A valid flag tracks whichever latency is in force. Outputs are plain logic: lanes that are not driven read as zero.

`ADDR_W` sets the depth as 2^ADDR_W words. Values of 14, 15 and 16 give 16K, 32K and 64K words. The default is kept small so that elaboration stays cheap.

Top module: `dual_lane_ram`

## Requirements
- R1: A port is selected on a rising edge only when `x_en_n` is 0 and `x_en` is 1. An unselected edge writes nothing, and its read slot carries `x_rvld`=0 with all-zero data.
- R2: On a selected edge, `x_wr_n`=0 writes the addressed word and produces no valid read. `x_wr_n`=1 reads the word.
- R3: A write changes bits [LANE_W-1:0] only when `x_lo_n`=0, and bits [DATA_W-1:LANE_W] only when `x_hi_n`=0. A lane whose select is 1 keeps its old contents.
- R4: LANE_W is DATA_W/2, which is 9 bits for DATA_W=18. Bit 8 therefore belongs to the low lane.
- R5: A lane of `x_rdata` shows read data only while `x_oe_n` is 0 and that lane was selected in the read that produced it. In every other case the lane reads 0.
- R6: With `x_pipe`=0 (flow-through), read data and `x_rvld`=1 appear after the first rising edge that follows the read edge.
- R7: With `x_pipe`=1 (pipelined), read data and `x_rvld`=1 appear after the second rising edge that follows the read edge.
- R8: The two ports work independently. A word written through one port can be read through the other, and both ports can read during the same cycle.
- R9: When both ports run from one clock and one port writes a word on the same edge that the other port reads it, the read returns the value from before the write.
- R10: Each port has a synchronous active-low reset. An edge with `x_rst_n`=0 clears that port's `x_rvld` and its output data to 0. The memory contents are kept.
- R11: `x_rvld` is 1 exactly when `x_rdata` carries the result of a read at the latency selected by the current `x_pipe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A synchronous active-low reset |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A: 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_lo_n | input | 1 | Port A low-lane select, active low |
| a_hi_n | input | 1 | Port A high-lane select, active low |
| a_pipe | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, gated per lane |
| a_rvld | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B synchronous active-low reset |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B: 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_lo_n | input | 1 | Port B low-lane select, active low |
| b_hi_n | input | 1 | Port B high-lane select, active low |
| b_pipe | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, gated per lane |
| b_rvld | output | 1 | Port B read data valid |

## Verification
The latency properties assume that `x_pipe` stays unchanged for the cycles they span. The stimulus therefore changes the mode only between phases, and only after idle cycles. The assertions also assume that the two ports never write the same word in overlapping cycles, because in that case the stored lanes are undefined. The stimulus never issues such writes. It reads only words it has written before, and it runs both ports from one clock so that the same-edge write-then-read case has a defined answer.

// File: rtl/dlr_pkg.sv
// Package: shared types and helpers for the dual-port byte-lane RAM.
// Assumes a word is made of exactly two equal byte lanes.
package dlr_pkg;
    localparam int NUM_LANES = 2;

    // Output latency choice for one port
    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;

    // Width of one byte lane for a given word width
    function automatic int lane_width(input int data_w);
        return data_w / NUM_LANES;
    endfunction
endpackage

// File: rtl/dlr_port_decode.sv
// Module: per-port control decode.
// Combines the two chip enables, the read/write line and the lane
// selects into read, write and per-lane strobes for one clock edge.
// Assumes all inputs are synchronous to the port clock.
module dlr_port_decode (
    input  logic       en_n,
    input  logic       en,
    input  logic       wr_n,
    input  logic       lo_n,
    input  logic       hi_n,
    output logic       rd_go,
    output logic       wr_go,
    output logic [1:0] lane_sel
);
    logic selected;

    // Port selected only when both enables are in their active state
    always_comb begin
        selected = !en_n && en;
        rd_go    = selected && wr_n;
        wr_go    = selected && !wr_n;
        lane_sel = ~{hi_n, lo_n};
    end
endmodule

// File: rtl/dlr_bank.sv
// Module: one storage bank, written only by its owning port.
// Two banks are XOR-combined so that each has a single writer clock.
// A word's live value is bank_A[x] ^ bank_B[x]. The owner stores
// (new data ^ other bank) so that the combination yields the new data.
// Assumes the write data arrives already XOR-coded by the caller.
module dlr_bank #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              we,
    input  logic [1:0]        lane_we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wcode,
    input  logic [ADDR_W-1:0] raddr_own,
    input  logic [ADDR_W-1:0] raddr_oth,
    output logic [DATA_W-1:0] rd_own,
    output logic [DATA_W-1:0] rd_oth
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = dlr_pkg::lane_width(DATA_W);

    logic [DATA_W-1:0] cells [DEPTH];

    // Lane-masked write from the owning port clock
    always_ff @(posedge clk) begin
        for (int l = 0; l < dlr_pkg::NUM_LANES; l++) begin
            if (we && lane_we[l]) begin
                cells[waddr][l*LANE_W +: LANE_W] <= wcode[l*LANE_W +: LANE_W];
            end
        end
    end

    // Asynchronous look-ups for the own port and the other port
    always_comb begin
        rd_own = cells[raddr_own];
        rd_oth = cells[raddr_oth];
    end
endmodule

// File: rtl/dlr_read_path.sv
// Module: read output path for one port.
// Stage 1 captures the word and the lane selects on a read edge.
// Stage 2 delays stage 1 by one clock. The latency select picks a
// stage, and the output enable plus the captured lane selects gate each lane.
// Assumes a synchronous active-low reset on the port clock.
module dlr_read_path #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] word,
    input  logic              pipe,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvld
);
    import dlr_pkg::*;
    localparam int LANE_W = lane_width(DATA_W);

    typedef struct packed {
        logic              vld;
        logic [1:0]        lanes;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t    st1, st2, pick;
    lat_mode_e mode;

    // First stage: capture a read, otherwise mark the slot empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= '0;
        end else if (rd_go) begin
            st1.vld   <= 1'b1;
            st1.lanes <= lane_sel;
            st1.data  <= word;
        end else begin
            st1.vld   <= 1'b0;
            st1.lanes <= 2'b00;
        end
    end

    // Second stage: one extra register for pipelined latency
    always_ff @(posedge clk) begin
        if (!rst_n) st2 <= '0;
        else        st2 <= st1;
    end

    // Latency select between the two stages
    always_comb begin
        mode = lat_mode_e'(pipe);
        pick = (mode == LAT_PIPE) ? st2 : st1;
    end

    // Per-lane output gating by output enable and captured lane select
    generate
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            assign rdata[l*LANE_W +: LANE_W] =
                (!oe_n && pick.lanes[l]) ? pick.data[l*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    assign rvld = pick.vld;
endmodule

// File: rtl/dual_lane_ram.sv
// Module: true dual-port synchronous RAM with byte lanes and a per-port
// flow-through or pipelined read latency.
// Storage is two XOR-combined banks, one written by each port, so every
// register array has exactly one writer clock. Reads see the array as it
// was before the edge (read-before-write). When both ports write the same
// word in overlapping cycles, the stored lanes are undefined.
module dual_lane_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic              a_en_n,
    input  logic              a_en,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic              a_lo_n,
    input  logic              a_hi_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvld,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_en_n,
    input  logic              b_en,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic              b_lo_n,
    input  logic              b_hi_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvld
);
    localparam int NP = 2;

    logic              clk_v   [NP];
    logic              rst_v   [NP];
    logic              en_n_v  [NP];
    logic              en_v    [NP];
    logic              wr_n_v  [NP];
    logic              oe_n_v  [NP];
    logic              lo_n_v  [NP];
    logic              hi_n_v  [NP];
    logic              pipe_v  [NP];
    logic [ADDR_W-1:0] addr_v  [NP];
    logic [DATA_W-1:0] wdata_v [NP];
    logic [DATA_W-1:0] rdata_v [NP];
    logic              rvld_v  [NP];
    logic              rd_go   [NP];
    logic              wr_go   [NP];
    logic [1:0]        lanes   [NP];
    logic [DATA_W-1:0] own_rd  [NP];
    logic [DATA_W-1:0] oth_rd  [NP];
    logic [DATA_W-1:0] word_v  [NP];

    // Gather port A pins into index 0
    always_comb begin
        clk_v[0] = a_clk;   rst_v[0] = a_rst_n; en_n_v[0] = a_en_n;
        en_v[0]  = a_en;    wr_n_v[0] = a_wr_n; oe_n_v[0] = a_oe_n;
        lo_n_v[0] = a_lo_n; hi_n_v[0] = a_hi_n; pipe_v[0] = a_pipe;
        addr_v[0] = a_addr; wdata_v[0] = a_wdata;
    end

    // Gather port B pins into index 1
    always_comb begin
        clk_v[1] = b_clk;   rst_v[1] = b_rst_n; en_n_v[1] = b_en_n;
        en_v[1]  = b_en;    wr_n_v[1] = b_wr_n; oe_n_v[1] = b_oe_n;
        lo_n_v[1] = b_lo_n; hi_n_v[1] = b_hi_n; pipe_v[1] = b_pipe;
        addr_v[1] = b_addr; wdata_v[1] = b_wdata;
    end

    assign a_rdata = rdata_v[0];
    assign a_rvld  = rvld_v[0];
    assign b_rdata = rdata_v[1];
    assign b_rvld  = rvld_v[1];

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            localparam int Q = NP - 1 - p;

            dlr_port_decode u_dec (
                .en_n     (en_n_v[p]),
                .en       (en_v[p]),
                .wr_n     (wr_n_v[p]),
                .lo_n     (lo_n_v[p]),
                .hi_n     (hi_n_v[p]),
                .rd_go    (rd_go[p]),
                .wr_go    (wr_go[p]),
                .lane_sel (lanes[p])
            );

            // Live word at this port's address: own bank XOR other bank
            assign word_v[p] = own_rd[p] ^ oth_rd[Q];

            dlr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
                .clk       (clk_v[p]),
                .we        (wr_go[p]),
                .lane_we   (lanes[p]),
                .waddr     (addr_v[p]),
                .wcode     (wdata_v[p] ^ oth_rd[Q]),
                .raddr_own (addr_v[p]),
                .raddr_oth (addr_v[Q]),
                .rd_own    (own_rd[p]),
                .rd_oth    (oth_rd[p])
            );

            dlr_read_path #(.DATA_W(DATA_W)) u_rd (
                .clk      (clk_v[p]),
                .rst_n    (rst_v[p]),
                .rd_go    (rd_go[p]),
                .lane_sel (lanes[p]),
                .word     (word_v[p]),
                .pipe     (pipe_v[p]),
                .oe_n     (oe_n_v[p]),
                .rdata    (rdata_v[p]),
                .rvld     (rvld_v[p])
            );
        end
    endgenerate
endmodule

// File: rtl/dlr_checker.sv
// Module: protocol and latency properties for dual_lane_ram, bound to the top.
// Assumes the latency select stays steady across each property's window.
module dlr_checker #(
    parameter int DATA_W = 18
) (
    input logic              a_clk,
    input logic              a_rst_n,
    input logic              a_en_n,
    input logic              a_en,
    input logic              a_wr_n,
    input logic              a_oe_n,
    input logic              a_pipe,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvld,
    input logic              b_clk,
    input logic              b_rst_n,
    input logic              b_en_n,
    input logic              b_en,
    input logic              b_wr_n,
    input logic              b_oe_n,
    input logic              b_pipe,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvld
);
    // R10: a reset edge leaves the port idle and quiet
    p_reset_idle_r10: assert property (@(posedge a_clk)
        !a_rst_n |=> (!a_rvld && a_rdata == '0));
    p_reset_idle_b_r10: assert property (@(posedge b_clk)
        !b_rst_n |=> (!b_rvld && b_rdata == '0));

    // R5: output enable high forces all lanes to zero
    p_oe_gate_r5: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        a_oe_n |-> a_rdata == '0);
    p_oe_gate_b_r5: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_oe_n |-> b_rdata == '0);

    // R1: an unselected edge in flow-through mode yields no valid data
    p_unsel_idle_r1: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!(!a_en_n && a_en) && !a_pipe) |=> (a_pipe || !a_rvld));

    // R2: a write edge produces no valid read
    p_write_novld_r2: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_en_n && a_en && !a_wr_n && !a_pipe) |=> (a_pipe || !a_rvld));

    // R6: a flow-through read is valid after one edge
    p_flow_lat_r6: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_en_n && b_en && b_wr_n && !b_pipe) |=> (b_pipe || b_rvld));

    // R7: a pipelined read is valid after two edges
    p_pipe_lat_r7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_en_n && b_en && b_wr_n && b_pipe) ##1 b_pipe |=> b_rvld);

    // R11: an unselected edge in pipelined mode gives no valid slot
    p_pipe_empty_r11: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!(!b_en_n && b_en) && b_pipe) ##1 b_pipe |=> !b_rvld);
endmodule

bind dual_lane_ram dlr_checker #(.DATA_W(DATA_W)) u_chk (
    .a_clk   (a_clk),
    .a_rst_n (a_rst_n),
    .a_en_n  (a_en_n),
    .a_en    (a_en),
    .a_wr_n  (a_wr_n),
    .a_oe_n  (a_oe_n),
    .a_pipe  (a_pipe),
    .a_rdata (a_rdata),
    .a_rvld  (a_rvld),
    .b_clk   (b_clk),
    .b_rst_n (b_rst_n),
    .b_en_n  (b_en_n),
    .b_en    (b_en),
    .b_wr_n  (b_wr_n),
    .b_oe_n  (b_oe_n),
    .b_pipe  (b_pipe),
    .b_rdata (b_rdata),
    .b_rvld  (b_rvld)
);

// File: tb/sim_dual_lane_ram.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock for both ports.
module sim_dual_lane_ram;
    localparam int AW = 10;
    localparam int DW = 18;
    localparam int LW = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          a_en_n, a_en, a_wr_n, a_oe_n, a_lo_n, a_hi_n, a_pipe;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata, a_rdata;
    logic          a_rvld;
    logic          b_en_n, b_en, b_wr_n, b_oe_n, b_lo_n, b_hi_n, b_pipe;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;
    logic          b_rvld;

    dual_lane_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .a_clk(clk), .a_rst_n(rst_n), .a_en_n(a_en_n), .a_en(a_en),
        .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_lo_n(a_lo_n), .a_hi_n(a_hi_n),
        .a_pipe(a_pipe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_rvld(a_rvld),
        .b_clk(clk), .b_rst_n(rst_n), .b_en_n(b_en_n), .b_en(b_en),
        .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_lo_n(b_lo_n), .b_hi_n(b_hi_n),
        .b_pipe(b_pipe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_rvld(b_rvld)
    );

    // Reference model state
    logic [DW-1:0] mref [0:(1<<AW)-1];
    logic [DW-1:0] s1d [2], s2d [2];
    logic [1:0]    s1l [2], s2l [2];
    logic          s1v [2], s2v [2];
    int checks = 0;
    int errors = 0;
    string tag = "R10";

    // Advance one port's read stages from the inputs seen at the edge
    task automatic stage_step(input int p, input logic en_n, en, wr_n,
                              lo_n, hi_n, input logic [DW-1:0] w);
        if (!rst_n) begin
            s1v[p] = 0; s1l[p] = 0; s1d[p] = 0;
            s2v[p] = 0; s2l[p] = 0; s2d[p] = 0;
        end else begin
            s2v[p] = s1v[p]; s2l[p] = s1l[p]; s2d[p] = s1d[p];
            if (!en_n && en && wr_n) begin
                s1v[p] = 1; s1l[p] = ~{hi_n, lo_n}; s1d[p] = w;
            end else begin
                s1v[p] = 0; s1l[p] = 0;
            end
        end
    endtask

    // Apply a lane-masked write to the model memory
    task automatic mem_write(input logic en_n, en, wr_n, lo_n, hi_n,
                             input logic [AW-1:0] ad, input logic [DW-1:0] d);
        if (!en_n && en && !wr_n) begin
            if (!lo_n) mref[ad][LW-1:0]  = d[LW-1:0];
            if (!hi_n) mref[ad][DW-1:LW] = d[DW-1:LW];
        end
    endtask

    // Model of one rising edge: reads see memory before this edge's writes
    task automatic model_edge();
        logic [DW-1:0] wa, wb;
        wa = mref[a_addr];
        wb = mref[b_addr];
        stage_step(0, a_en_n, a_en, a_wr_n, a_lo_n, a_hi_n, wa);
        stage_step(1, b_en_n, b_en, b_wr_n, b_lo_n, b_hi_n, wb);
        mem_write(a_en_n, a_en, a_wr_n, a_lo_n, a_hi_n, a_addr, a_wdata);
        mem_write(b_en_n, b_en, b_wr_n, b_lo_n, b_hi_n, b_addr, b_wdata);
    endtask

    // Compare one port with its expected output
    task automatic cmp_port(input int p, input logic pipe, oe_n,
                            input logic [DW-1:0] got_d, input logic got_v);
        logic [DW-1:0] ed;
        logic [1:0]    el;
        logic          ev;
        ed = pipe ? s2d[p] : s1d[p];
        el = pipe ? s2l[p] : s1l[p];
        ev = pipe ? s2v[p] : s1v[p];
        if (oe_n || !el[0]) ed[LW-1:0]  = '0;
        if (oe_n || !el[1]) ed[DW-1:LW] = '0;
        checks++;
        if (got_v !== ev || got_d !== ed) begin
            errors++;
            $display("FAIL %s port%0d rvld=%0b rdata=%h expected rvld=%0b rdata=%h",
                     tag, p, got_v, got_d, ev, ed);
        end
    endtask

    // One clock: model at the edge, compare away from it
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp_port(0, a_pipe, a_oe_n, a_rdata, a_rvld);
        cmp_port(1, b_pipe, b_oe_n, b_rdata, b_rvld);
    endtask

    task automatic drv_a(input logic en_n, en, wr_n, lo_n, hi_n, oe_n, pipe,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        a_en_n = en_n; a_en = en; a_wr_n = wr_n; a_lo_n = lo_n; a_hi_n = hi_n;
        a_oe_n = oe_n; a_pipe = pipe; a_addr = ad; a_wdata = d;
    endtask

    task automatic drv_b(input logic en_n, en, wr_n, lo_n, hi_n, oe_n, pipe,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        b_en_n = en_n; b_en = en; b_wr_n = wr_n; b_lo_n = lo_n; b_hi_n = hi_n;
        b_oe_n = oe_n; b_pipe = pipe; b_addr = ad; b_wdata = d;
    endtask

    task automatic idle(input logic pipe);
        drv_a(1, 1, 1, 0, 0, 0, pipe, '0, '0);
        drv_b(1, 1, 1, 0, 0, 0, pipe, '0, '0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            s1v[p] = 0; s1l[p] = 0; s1d[p] = 0;
            s2v[p] = 0; s2l[p] = 0; s2d[p] = 0;
        end
        rst_n = 0;
        idle(0);
        // R10: reset state
        tag = "R10";
        repeat (3) tick();
        rst_n = 1;

        // R2: port A fills words 0..7 with full-lane writes
        tag = "R2";
        for (int i = 0; i < 8; i++) begin
            drv_a(0, 1, 0, 0, 0, 0, 0, AW'(i), DW'(18'h1_2345 + i * 18'h0_4F31));
            tick();
        end
        idle(0); tick();

        // R8 R6: B reads 0..7 while A reads 7..0 in flow-through mode
        tag = "R8 R6";
        for (int i = 0; i < 8; i++) begin
            drv_b(0, 1, 1, 0, 0, 0, 0, AW'(i), '0);
            drv_a(0, 1, 1, 0, 0, 0, 0, AW'(7 - i), '0);
            tick();
        end
        idle(0); tick(); tick();

        // R3 R4: lane-only writes; bit 8 belongs to the low lane
        tag = "R3 R4";
        drv_a(0, 1, 0, 0, 1, 0, 0, AW'(2), 18'h3_FFFF); tick();
        drv_a(0, 1, 0, 1, 0, 0, 0, AW'(3), 18'h0_0000); tick();
        drv_a(0, 1, 0, 1, 0, 0, 0, AW'(4), 18'h2_AB55); tick();
        idle(0);
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(2), '0); tick();
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(3), '0); tick();
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(4), '0); tick();
        idle(0); tick();

        // R1: unselected writes change nothing; unselected reads are idle
        tag = "R1";
        drv_a(1, 1, 0, 0, 0, 0, 0, AW'(5), 18'h0_0BAD); tick();
        drv_a(0, 0, 0, 0, 0, 0, 0, AW'(6), 18'h0_0BAD); tick();
        drv_a(1, 0, 1, 0, 0, 0, 0, AW'(5), '0); tick();
        idle(0);
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(5), '0); tick();
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(6), '0); tick();
        idle(0); tick();

        // R5: output enable and per-lane read gating
        tag = "R5";
        drv_b(0, 1, 1, 0, 0, 1, 0, AW'(1), '0); tick();
        drv_b(1, 1, 1, 0, 0, 0, 0, AW'(1), '0); tick();
        drv_b(0, 1, 1, 0, 1, 0, 0, AW'(1), '0); tick();
        drv_b(0, 1, 1, 1, 0, 0, 0, AW'(1), '0); tick();
        drv_b(0, 1, 1, 1, 1, 0, 0, AW'(1), '0); tick();
        idle(0); tick();

        // R7 R11: pipelined latency on both ports
        tag = "R7 R11";
        idle(1); tick(); tick();
        for (int i = 0; i < 6; i++) begin
            drv_b(0, 1, 1, 0, 0, 0, 1, AW'(i), '0);
            if (i % 2 == 0) drv_a(0, 1, 1, 0, 0, 0, 1, AW'(i + 1), '0);
            else            drv_a(1, 1, 1, 0, 0, 0, 1, '0, '0);
            tick();
        end
        drv_a(0, 1, 0, 0, 0, 0, 1, AW'(9), 18'h1_5A5A); tick();
        drv_b(0, 1, 1, 0, 0, 0, 1, AW'(9), '0);
        drv_a(1, 1, 1, 0, 0, 0, 1, '0, '0); tick();
        idle(1); tick(); tick(); tick();
        idle(0); tick(); tick();

        // R9: same-edge write on A and read on B return the old word
        tag = "R9";
        drv_a(0, 1, 0, 0, 0, 0, 0, AW'(7), 18'h3_C0DE);
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(7), '0); tick();
        idle(0);
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(7), '0); tick();
        idle(0); tick();

        // R10: reset mid-run clears outputs but keeps memory
        tag = "R10";
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(7), '0); tick();
        rst_n = 0; idle(0); tick();
        rst_n = 1; tick();
        drv_b(0, 1, 1, 0, 0, 0, 0, AW'(7), '0); tick();
        idle(0); tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule